// File: doc/BRIEF.md
# Complex Pilot/Data Chip Spreader

This block turns two channels into one complex chip stream for a direct sequence spread spectrum transmitter. The in-phase rail carries a pilot channel that the block makes by itself. The pilot symbol is always +1, and it is spread by a fixed alternating code. The quadrature rail carries user data bits, which arrive one at a time through a valid/ready handshake. Each data bit is spread by a 16-chip channelization code that software can load.

A two-state controller runs the block. In the configuration state, the outputs are idle and the data code may be rewritten. When `run` is raised, the block enters the chipping state. There it emits one chip per rail per clock, 16 chips per symbol, and takes a new data bit only at the first chip of each symbol. When `run` is lowered, the current symbol is completed before the block returns to configuration. Each output chip is a 2-bit signed value of +1 or -1.

Top module: `dsss_cplx_spreader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to the configuration state. After that edge, `chip_i` and `chip_q` are 2'b00, `chip_valid`, `chip_strobe`, `underrun` and `bit_ready` are 0, the data code is 16'hC3C3, and the held data bit is 0.
- R2: A `cfg_we` pulse loads `cfg_code` into the data code only in the configuration state. While chipping, `cfg_we` has no effect on the chips.
- R3: When `run` is high in the configuration state, chipping starts on the next edge. From then on, each clock gives one valid chip pair (`chip_valid`=1) with chip index 0 to 15, and the index wraps to 0.
- R4: The chip on `chip_i` at index k is +1 when bit (15-k) of 16'hAAAA is 1 and -1 otherwise. The chip at index 0 is the leftmost bit, so the rail starts +1 and then alternates.
- R5: The chip on `chip_q` at index k is +1 when the symbol's data bit equals bit (15-k) of the data code, and -1 otherwise. The encoding is +1 = 2'b01 and -1 = 2'b11. Both rails read 2'b00 whenever `chip_valid` is 0.
- R6: `bit_ready` is high only while chipping at index 0. A bit is taken when `bit_valid` and `bit_ready` are both high, and it is used for all 16 chips of that symbol.
- R7: If `bit_valid` is low at index 0, the previous data bit is reused for the new symbol, and `underrun` is high for that symbol's index-0 chip only.
- R8: `chip_strobe` is high exactly on the output cycle that carries chip index 0.
- R9: If `run` is low at index 15, chipping stops after that chip and the block re-enters the configuration state. If `run` drops at an earlier index, the symbol still completes.
- R10: A reset during chipping discards the symbol in progress and restores the default data code. Chipping then restarts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start and keep chipping; when low, stop at the end of the symbol |
| cfg_we | input | 1 | Write strobe for the data code |
| cfg_code | input | 16 | New data channelization code, first chip in the MSB |
| bit_valid | input | 1 | Data bit available |
| bit_data | input | 1 | Data bit, 1 = +1, 0 = -1 |
| bit_ready | output | 1 | Block takes a bit this cycle |
| chip_i | output | 2 | Pilot rail chip, signed |
| chip_q | output | 2 | Data rail chip, signed |
| chip_valid | output | 1 | Chip pair valid |
| chip_strobe | output | 1 | Chip index 0 marker |
| underrun | output | 1 | No bit at symbol start; previous bit reused |

## Verification
The embedded assertions check several rules on every cycle: rail values are legal, both rails are zero when no chip is valid, the pilot rail alternates inside a symbol, a strobe follows every handshake slot, underrun appears only with the strobe, and the code register is frozen within a symbol. Some behaviours can only be shown by the bench's scenarios. These are the exact chip values against the loaded code, the reuse of the held bit on underrun, code writes that are ignored while chipping, a stop that completes the current symbol, and the restore of the default code after a reset in mid-run.

// File: rtl/dsss_cplx_spreader.sv
module dsss_cplx_spreader #(
  parameter int CODE_LEN = 16,
  parameter logic [CODE_LEN-1:0] PILOT_CODE = 16'hAAAA,
  parameter logic [CODE_LEN-1:0] DEFAULT_CODE = 16'hC3C3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                cfg_we,
  input  logic [CODE_LEN-1:0] cfg_code,
  input  logic                bit_valid,
  input  logic                bit_data,
  output logic                bit_ready,
  output logic [1:0]          chip_i,
  output logic [1:0]          chip_q,
  output logic                chip_valid,
  output logic                chip_strobe,
  output logic                underrun
);
  localparam int IW = $clog2(CODE_LEN);
  localparam logic [IW-1:0] LAST = IW'(CODE_LEN - 1);

  typedef enum logic {S_CFG, S_CHIP} st_t;
  st_t st;
  logic [IW-1:0] idx;
  logic held;
  logic [CODE_LEN-1:0] code_q;

  wire at_start = (st == S_CHIP) && (idx == '0);
  wire sym = at_start ? (bit_valid ? bit_data : held) : held;
  wire [IW-1:0] pos = LAST - idx;
  wire pil_c = PILOT_CODE[pos];
  wire dat_c = code_q[pos];

  assign bit_ready = at_start;

  function automatic logic [1:0] pm(input logic b);
    return b ? 2'b01 : 2'b11;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_CFG;
      idx         <= '0;
      held        <= 1'b0;
      code_q      <= DEFAULT_CODE;
      chip_i      <= 2'b00;
      chip_q      <= 2'b00;
      chip_valid  <= 1'b0;
      chip_strobe <= 1'b0;
      underrun    <= 1'b0;
    end else begin
      case (st)
        S_CFG: begin
          chip_i      <= 2'b00;
          chip_q      <= 2'b00;
          chip_valid  <= 1'b0;
          chip_strobe <= 1'b0;
          underrun    <= 1'b0;
          if (cfg_we) code_q <= cfg_code;
          if (run) begin
            st  <= S_CHIP;
            idx <= '0;
          end
        end
        default: begin
          chip_i      <= pm(pil_c);
          chip_q      <= pm(~(sym ^ dat_c));
          chip_valid  <= 1'b1;
          chip_strobe <= (idx == '0);
          underrun    <= at_start && !bit_valid;
          if (at_start) held <= sym;
          if (idx == LAST) begin
            idx <= '0;
            if (!run) st <= S_CFG;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end

  a_r8_ready_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |=> chip_strobe);
  a_r5_rails_legal: assert property (@(posedge clk) disable iff (!rst_n)
    chip_valid |-> ((chip_i == 2'b01 || chip_i == 2'b11) && (chip_q == 2'b01 || chip_q == 2'b11)));
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_valid |-> (chip_i == 2'b00 && chip_q == 2'b00));
  a_r4_pilot_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_valid && !chip_strobe) |-> (chip_i != $past(chip_i)));
  a_r7_underrun_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> chip_strobe);
  a_r2_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_valid && !chip_strobe) |-> $stable(code_q));
endmodule

// File: tb/test_dsss_cplx_spreader.sv
`timescale 1ns/1ps
module test_dsss_cplx_spreader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_code = '0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic bit_ready;
  logic [1:0] chip_i, chip_q;
  logic chip_valid, chip_strobe, underrun;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string ctx = "R1";

  localparam logic [15:0] PIL = 16'hAAAA;
  localparam logic [15:0] DEF = 16'hC3C3;

  bit m_st;
  int m_idx;
  bit m_held;
  logic [15:0] m_code;

  always #2 clk = ~clk;

  dsss_cplx_spreader i_dsss_cplx_spreader (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .chip_i(chip_i), .chip_q(chip_q), .chip_valid(chip_valid),
    .chip_strobe(chip_strobe), .underrun(underrun));

  function automatic logic [1:0] enc(input bit b);
    return b ? 2'b01 : 2'b11;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", what, ctx, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_idx = 0; m_held = 0; m_code = DEF;
  endtask

  task automatic tick();
    bit e_ready, e_valid, e_strobe, e_under, sym;
    logic [1:0] e_i, e_q;
    #1;
    e_ready = m_st && (m_idx == 0);
    chk(bit_ready == e_ready, "R6 bit_ready", bit_ready, e_ready);
    if (m_st) begin
      sym = (m_idx == 0) ? (bit_valid ? bit_data : m_held) : m_held;
      e_valid = 1; e_strobe = (m_idx == 0); e_under = (m_idx == 0) && !bit_valid;
      e_i = enc(PIL[15-m_idx]);
      e_q = enc(sym == m_code[15-m_idx]);
      if (m_idx == 0) m_held = sym;
      if (m_idx == 15) begin
        m_idx = 0;
        if (!run) m_st = 0;
      end else m_idx++;
    end else begin
      e_valid = 0; e_strobe = 0; e_under = 0; e_i = 2'b00; e_q = 2'b00;
      if (cfg_we) m_code = cfg_code;
      if (run) begin m_st = 1; m_idx = 0; end
    end
    @(posedge clk);
    @(negedge clk);
    chk(chip_valid == e_valid, "R3/R9 chip_valid", chip_valid, e_valid);
    chk(chip_strobe == e_strobe, "R8 chip_strobe", chip_strobe, e_strobe);
    chk(underrun == e_under, "R7 underrun", underrun, e_under);
    chk(chip_i == e_i, "R4 chip_i", chip_i, e_i);
    chk(chip_q == e_q, "R5 chip_q", chip_q, e_q);
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
    chk(chip_valid == 0 && chip_strobe == 0 && underrun == 0, "R1 flags", chip_valid, 0);
    chk(chip_i == 2'b00 && chip_q == 2'b00, "R1 rails", chip_i, 0);
    chk(bit_ready == 0, "R1 bit_ready", bit_ready, 0);
  endtask

  task automatic rand_cycle(input int valid_pct, input bit try_write);
    bit_valid = ($urandom % 100) < valid_pct;
    bit_data = $urandom % 2;
    cfg_we = try_write ? ($urandom % 2) : 1'b0;
    cfg_code = $urandom;
    tick();
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    ctx = "R1";
    run = 1;
    do_reset();
    run = 0;
    repeat (3) rand_cycle(100, 0);

    ctx = "R3";
    run = 1;
    repeat (1 + 16 * 3) rand_cycle(100, 0);

    ctx = "R7";
    repeat (16 * 2) rand_cycle(0, 0);

    ctx = "R9";
    repeat (5) rand_cycle(100, 0);
    run = 0;
    repeat (16 + 3) rand_cycle(100, 0);

    ctx = "R2";
    for (int n = 0; n < 6; n++) begin
      run = 0;
      cfg_we = 1; cfg_code = $urandom;
      tick();
      cfg_we = 0;
      run = 1;
      repeat (1 + 16 * 8) rand_cycle(70, 1);
      run = 0;
      repeat (17) rand_cycle(70, 1);
    end

    ctx = "R10";
    cfg_we = 1; cfg_code = 16'h1234; run = 0;
    tick();
    cfg_we = 0; run = 1;
    repeat (9) rand_cycle(100, 0);
    do_reset();
    repeat (1 + 16 * 4) rand_cycle(50, 1);
    run = 0;
    repeat (20) rand_cycle(100, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog [%s] actual=%0d expected=%0d", ctx, 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule